// File: doc/BRIEF.md
# Two-Pulse Clutter Canceller

This block removes stationary clutter from a stream of complex range samples before Doppler processing. It keeps the sample from the preceding chirp for every range bin. For each new sample it outputs the difference between the new sample and the stored one, which gives the first-order slow-time filter H(z) = 1 − z⁻¹. Returns that do not change from chirp to chirp, such as ground and fixed structures, cancel to zero. Moving targets leave a residue.

The input is a valid-qualified stream of signed I/Q samples. A marker input is raised on the first range bin of each chirp. A single enable input selects between cancelling and exact pass-through. After reset, and whenever cancelling is switched on, the block outputs zeros for one whole marked chirp. This fills the history so that a stale or missing earlier chirp is never subtracted. The number of bins per chirp and the sample width are parameters.

Top module: `mti_canceller`

## Requirements
- R1: With cancelling on and the history filled, each output I and Q equals the current sample minus the sample received for the same range bin in the previous chirp, computed separately for I and Q.
- R2: A return that is identical in consecutive chirps produces a zero output in that range bin.
- R3: With `mti_on` low, each output equals the input sample sign-extended to DATA_W+1 bits, with no other change.
- R4: Outputs are DATA_W+1 bits wide, so that the extreme differences (max − min = 2^DATA_W − 1 and min − max = −(2^DATA_W − 1)) are exact.
- R5: After reset, or after `mti_on` rises, every output is zero until one chirp that starts with a marker has been received in full while cancelling is on. Differences start with the next sample.
- R6: `out_valid` is `in_valid` delayed by exactly one clock. In a cycle without `in_valid`, `out_i` and `out_q` keep their values. Reset clears `out_valid`, `out_first`, `out_i` and `out_q` to 0.
- R7: `in_first` restarts the range-bin index at bin 0. `out_first` is `in_first` delayed by one clock and aligned with its sample.
- R8: Without a marker, the range-bin index wraps from NUM_BINS−1 to 0, so back-to-back chirps still pair each sample with the correct bin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mti_on | input | 1 | 1 = cancel, 0 = pass-through |
| in_valid | input | 1 | Input sample qualifier |
| in_first | input | 1 | Marks range bin 0 of a chirp |
| in_i | input | DATA_W | Input in-phase sample, signed |
| in_q | input | DATA_W | Input quadrature sample, signed |
| out_valid | output | 1 | Output sample qualifier |
| out_first | output | 1 | Marker aligned with the output sample |
| out_i | output | DATA_W+1 | Output in-phase, signed |
| out_q | output | DATA_W+1 | Output quadrature, signed |

## Verification
The canceller is driven with chirps of different data in every bin, so a difference taken against the wrong bin or the wrong chirp shows up as a wrong value. A repeated chirp checks that stationary returns go to zero. Full-scale opposite-sign pairs check that the extra output bit is present. A chirp sent without a marker separates correct wrap-around of the bin index from indexing that depends on the marker. The tests also cover a bypass chirp, a chirp right after the block is enabled again, enabling in the middle of a chirp, and reset in the middle of the stream. Together these show that pass-through is exact and that no stale history is ever subtracted.

// File: rtl/mti_pkg.sv
package mti_pkg;

  // History fill state: waiting for a marker, filling one chirp, ready.
  typedef enum logic [1:0] {
    PR_WAIT  = 2'd0,
    PR_FILL  = 2'd1,
    PR_READY = 2'd2
  } prime_state_t;

  localparam int LANES = 2;  // lane 0 = I, lane 1 = Q

endpackage

// File: rtl/mti_bin_counter.sv
module mti_bin_counter #(
  parameter int NUM_BINS = 64,
  localparam int BIN_W = (NUM_BINS > 1) ? $clog2(NUM_BINS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_first,
  output logic [BIN_W-1:0] bin_idx,
  output logic             last_bin
);

  localparam logic [BIN_W-1:0] LAST = BIN_W'(NUM_BINS - 1);

  logic [BIN_W-1:0] next_bin;

  // A marker forces bin 0 for the current sample.
  assign bin_idx  = in_first ? '0 : next_bin;
  assign last_bin = (bin_idx == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      next_bin <= '0;
    end else if (in_valid) begin
      next_bin <= last_bin ? '0 : bin_idx + 1'b1;
    end
  end

endmodule

// File: rtl/mti_history.sv
module mti_history #(
  parameter int DATA_W   = 16,
  parameter int NUM_BINS = 64,
  localparam int BIN_W   = (NUM_BINS > 1) ? $clog2(NUM_BINS) : 1,
  localparam int WORD_W  = 2 * DATA_W
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [BIN_W-1:0]         idx,
  input  logic signed [DATA_W-1:0] wr_i,
  input  logic signed [DATA_W-1:0] wr_q,
  output logic signed [DATA_W-1:0] rd_i,
  output logic signed [DATA_W-1:0] rd_q
);

  // One word per range bin. Asynchronous read, so the previous value is
  // read before the write at the clock edge (distributed storage).
  logic [WORD_W-1:0] mem [NUM_BINS];

  assign rd_i = mem[idx][WORD_W-1:DATA_W];
  assign rd_q = mem[idx][DATA_W-1:0];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[idx] <= {wr_i, wr_q};
    end
  end

endmodule

// File: rtl/mti_prime_ctrl.sv
module mti_prime_ctrl
  import mti_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic in_valid,
  input  logic in_first,
  input  logic last_bin,
  output logic ready
);

  prime_state_t state, state_n;

  always_comb begin
    state_n = state;
    if (!enable) begin
      state_n = PR_WAIT;
    end else if (in_valid) begin
      case (state)
        PR_WAIT:  if (in_first) state_n = last_bin ? PR_READY : PR_FILL;
        PR_FILL:  if (last_bin) state_n = PR_READY;
        default:  state_n = PR_READY;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= PR_WAIT;
    else     state <= state_n;
  end

  assign ready = (state == PR_READY);

endmodule

// File: rtl/mti_diff_stage.sv
module mti_diff_stage
  import mti_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int OUT_W = DATA_W + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic                     in_first,
  input  logic                     enable,
  input  logic                     ready,
  input  logic signed [DATA_W-1:0] cur  [LANES],
  input  logic signed [DATA_W-1:0] prev [LANES],
  output logic                     out_valid,
  output logic                     out_first,
  output logic signed [OUT_W-1:0]  out_d [LANES]
);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_first <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_first <= in_valid & in_first;
    end
  end

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    logic signed [OUT_W-1:0] cur_x, prev_x, res;

    assign cur_x  = {cur[ln][DATA_W-1], cur[ln]};
    assign prev_x = {prev[ln][DATA_W-1], prev[ln]};

    always_comb begin
      if (!enable)     res = cur_x;
      else if (!ready) res = '0;
      else             res = cur_x - prev_x;
    end

    always_ff @(posedge clk) begin
      if (rst)           out_d[ln] <= '0;
      else if (in_valid) out_d[ln] <= res;
    end
  end

endmodule

// File: rtl/mti_canceller.sv
module mti_canceller
  import mti_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NUM_BINS = 64,
  localparam int OUT_W   = DATA_W + 1,
  localparam int BIN_W   = (NUM_BINS > 1) ? $clog2(NUM_BINS) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     mti_on,
  input  logic                     in_valid,
  input  logic                     in_first,
  input  logic signed [DATA_W-1:0] in_i,
  input  logic signed [DATA_W-1:0] in_q,
  output logic                     out_valid,
  output logic                     out_first,
  output logic signed [OUT_W-1:0]  out_i,
  output logic signed [OUT_W-1:0]  out_q
);

  logic [BIN_W-1:0]         bin_idx;
  logic                     last_bin;
  logic                     armed;
  logic signed [DATA_W-1:0] hist_i, hist_q;
  logic signed [DATA_W-1:0] cur_v  [LANES];
  logic signed [DATA_W-1:0] prev_v [LANES];
  logic signed [OUT_W-1:0]  res_v  [LANES];

  mti_bin_counter #(.NUM_BINS(NUM_BINS)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_first (in_first),
    .bin_idx  (bin_idx),
    .last_bin (last_bin)
  );

  // History takes the raw sample on every valid input, in either mode.
  mti_history #(.DATA_W(DATA_W), .NUM_BINS(NUM_BINS)) u_hist (
    .clk   (clk),
    .wr_en (in_valid),
    .idx   (bin_idx),
    .wr_i  (in_i),
    .wr_q  (in_q),
    .rd_i  (hist_i),
    .rd_q  (hist_q)
  );

  mti_prime_ctrl u_prime (
    .clk      (clk),
    .rst      (rst),
    .enable   (mti_on),
    .in_valid (in_valid),
    .in_first (in_first),
    .last_bin (last_bin),
    .ready    (armed)
  );

  assign cur_v[0]  = in_i;
  assign cur_v[1]  = in_q;
  assign prev_v[0] = hist_i;
  assign prev_v[1] = hist_q;

  mti_diff_stage #(.DATA_W(DATA_W)) u_diff (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_first  (in_first),
    .enable    (mti_on),
    .ready     (armed),
    .cur       (cur_v),
    .prev      (prev_v),
    .out_valid (out_valid),
    .out_first (out_first),
    .out_d     (res_v)
  );

  assign out_i = res_v[0];
  assign out_q = res_v[1];

endmodule

// File: rtl/mti_canceller_chk.sv
module mti_canceller_chk #(
  parameter int DATA_W = 16,
  localparam int OUT_W = DATA_W + 1
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     mti_on,
  input logic                     in_valid,
  input logic                     in_first,
  input logic signed [DATA_W-1:0] in_i,
  input logic signed [DATA_W-1:0] in_q,
  input logic                     out_valid,
  input logic                     out_first,
  input logic signed [OUT_W-1:0]  out_i,
  input logic signed [OUT_W-1:0]  out_q,
  input logic                     armed
);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);  // R6

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);  // R6

  AST_HOLD_ON_GAP: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_i) && $stable(out_q)));  // R6

  AST_BYPASS_EXACT: assert property (@(posedge clk) disable iff (rst)
    (!mti_on && in_valid) |=>
      (out_i == {$past(in_i[DATA_W-1]), $past(in_i)}) &&
      (out_q == {$past(in_q[DATA_W-1]), $past(in_q)}));  // R3

  AST_UNPRIMED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (mti_on && !armed && in_valid) |=> (out_i == '0 && out_q == '0));  // R5

  AST_MARK_ALIGN: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_first == $past(in_first)));  // R7

endmodule

bind mti_canceller mti_canceller_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mti_on    (mti_on),
  .in_valid  (in_valid),
  .in_first  (in_first),
  .in_i      (in_i),
  .in_q      (in_q),
  .out_valid (out_valid),
  .out_first (out_first),
  .out_i     (out_i),
  .out_q     (out_q),
  .armed     (armed)
);

// File: tb/tb_mti_canceller.sv
module tb_mti_canceller;

  localparam int DW   = 8;
  localparam int NB   = 4;
  localparam int OW   = DW + 1;
  localparam int NROW = 24;

  typedef struct packed {
    logic                 en;
    logic                 first;
    logic signed [DW-1:0] i;
    logic signed [DW-1:0] q;
    logic signed [OW-1:0] ei;
    logic signed [OW-1:0] eq;
  } row_t;

  // Chirp A: fill (zeros), B: differences incl. extremes, C: no marker,
  // D: bypass, E: re-enabled fill (zeros), F: differences again.
  localparam row_t TBL [NROW] = '{
    '{1'b1, 1'b1,  8'sd10,  -8'sd5,  9'sd0,    9'sd0},
    '{1'b1, 1'b0,  8'sd20,   8'sd0,  9'sd0,    9'sd0},
    '{1'b1, 1'b0,  8'sd30,   8'sd5,  9'sd0,    9'sd0},
    '{1'b1, 1'b0,  8'sd40,  8'sh7f,  9'sd0,    9'sd0},
    '{1'b1, 1'b1,  8'sd13,  -8'sd5,  9'sd3,    9'sd0},
    '{1'b1, 1'b0,  8'sd20,   8'sd3,  9'sd0,    9'sd3},
    '{1'b1, 1'b0,  8'sd25,   8'sd0, -9'sd5,   -9'sd5},
    '{1'b1, 1'b0,  8'sh80,  8'sh80, -9'sd168, -9'sd255},
    '{1'b1, 1'b0,  8'sd13,  -8'sd5,  9'sd0,    9'sd0},
    '{1'b1, 1'b0,  8'sd20,   8'sd3,  9'sd0,    9'sd0},
    '{1'b1, 1'b0,  8'sd25,   8'sd0,  9'sd0,    9'sd0},
    '{1'b1, 1'b0,  8'sh7f,  8'sh7f,  9'sd255,  9'sd255},
    '{1'b0, 1'b1,  -8'sd1,   8'sd7, -9'sd1,    9'sd7},
    '{1'b0, 1'b0,   8'sd2,  -8'sd7,  9'sd2,   -9'sd7},
    '{1'b0, 1'b0,  8'sh80,   8'sd0, -9'sd128,  9'sd0},
    '{1'b0, 1'b0,  8'sh7f,   8'sd1,  9'sd127,  9'sd1},
    '{1'b1, 1'b1,   8'sd1,   8'sd1,  9'sd0,    9'sd0},
    '{1'b1, 1'b0,   8'sd1,   8'sd1,  9'sd0,    9'sd0},
    '{1'b1, 1'b0,   8'sd1,   8'sd1,  9'sd0,    9'sd0},
    '{1'b1, 1'b0,   8'sd1,   8'sd1,  9'sd0,    9'sd0},
    '{1'b1, 1'b1,   8'sd4,   8'sd1,  9'sd3,    9'sd0},
    '{1'b1, 1'b0,   8'sd1,   8'sd1,  9'sd0,    9'sd0},
    '{1'b1, 1'b0,   8'sd0,   8'sd1, -9'sd1,    9'sd0},
    '{1'b1, 1'b0,   8'sd1,   8'sd1,  9'sd0,    9'sd0}
  };

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 mti_on = 1'b0;
  logic                 in_valid = 1'b0;
  logic                 in_first = 1'b0;
  logic signed [DW-1:0] in_i = '0;
  logic signed [DW-1:0] in_q = '0;
  logic                 out_valid, out_first;
  logic signed [OW-1:0] out_i, out_q;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  mti_canceller #(.DATA_W(DW), .NUM_BINS(NB)) dut (
    .clk, .rst, .mti_on, .in_valid, .in_first, .in_i, .in_q,
    .out_valid, .out_first, .out_i, .out_q
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic string row_req(input int k);
    if (k < 4)  return "R5 first chirp";
    if (k < 8)  return "R1/R4 difference";
    if (k < 12) return "R2/R8 no-marker chirp";
    if (k < 16) return "R3 bypass";
    if (k < 20) return "R5 after re-enable";
    return "R1 difference";
  endfunction

  task automatic put(input logic en, input logic v, input logic f,
                     input logic signed [DW-1:0] i, input logic signed [DW-1:0] q);
    mti_on = en; in_valid = v; in_first = f; in_i = i; in_q = q;
  endtask

  task automatic show(input string req, input int ei, input int eq);
    chk({req, " valid"}, int'(out_valid), 1);
    chk({req, " I"}, int'(out_i), ei);
    chk({req, " Q"}, int'(out_q), eq);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // Reset state (R6)
    chk("R6 reset out_valid", int'(out_valid), 0);
    chk("R6 reset out_first", int'(out_first), 0);
    chk("R6 reset out_i", int'(out_i), 0);
    chk("R6 reset out_q", int'(out_q), 0);
    rst = 1'b0;

    // Vector table
    for (int k = 0; k <= NROW; k++) begin
      @(negedge clk);
      if (k > 0) begin
        show(row_req(k - 1), int'(TBL[k-1].ei), int'(TBL[k-1].eq));
        chk("R7 out_first", int'(out_first), int'(TBL[k-1].first));
      end
      if (k < NROW)
        put(TBL[k].en, 1'b1, TBL[k].first, TBL[k].i, TBL[k].q);
    end

    // Gap: no valid, data changes, outputs hold (R6)
    put(1'b1, 1'b0, 1'b0, 8'sd55, 8'sd55);
    @(negedge clk);
    chk("R6 gap out_valid", int'(out_valid), 0);
    chk("R6 gap hold I", int'(out_i), 0);

    // Enable in mid-chirp: no difference yet (R5)
    put(1'b0, 1'b1, 1'b1, 8'sd9, 8'sd9);
    @(negedge clk);
    put(1'b0, 1'b1, 1'b0, 8'sd9, 8'sd9);
    @(negedge clk);
    put(1'b1, 1'b1, 1'b0, 8'sd50, 8'sd50);
    @(negedge clk);
    show("R5 mid-chirp enable", 0, 0);
    put(1'b1, 1'b0, 1'b0, 8'sd0, 8'sd0);

    // Reset mid-stream, then fill chirp and one difference (R5, R1)
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int b = 0; b < NB; b++) begin
      put(1'b1, 1'b1, b == 0, 8'sd7, -8'sd7);
      @(negedge clk);
      show("R5 after reset", 0, 0);
    end
    put(1'b1, 1'b1, 1'b1, 8'sd8, -8'sd9);
    @(negedge clk);
    show("R1 after reset fill", 1, -2);
    put(1'b0, 1'b0, 1'b0, 8'sd0, 8'sd0);
    @(negedge clk);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule